// File: doc/BRIEF.md
# Width-Converting Dual-Clock FIFO

This block carries a data stream from one clock domain to an unrelated second clock domain. The writing side and the reading side use bus widths that differ by a power-of-two ratio, in either direction. When the writer is narrower, several narrow writes are collected into one wide word for the reader. When the reader is narrower, each wide word that is written comes back out as several narrow reads. Both sides see occupancy flags that are computed locally, so producers and consumers can throttle without waiting for a handshake.

Storage is a small array of wide entries. Each side keeps its own position counter in its own word units. That counter is converted to Gray code, registered, and passed through a two-stage synchroniser into the other domain. There it is decoded and scaled to narrow-word units. The full flag is derived in the write domain and the empty flag in the read domain. Both use the delayed copy of the other side's position, so they err on the safe side.

The near-full and near-empty levels are given in narrow-word units. A build-time parameter selects whether they come from two constant parameters or from two run-time inputs. Read data is presented combinationally from the head of the queue, so it is valid whenever the empty flag is low.

Top module: `xwidth_async_fifo`

## Requirements
- R1: After each side's asynchronous active-low reset, empty is 1, full is 0, almost-full is 0 (for a nonzero level) and almost-empty is 1.
- R2: With a narrow write side, RATIO successive writes form one read word, and the first write lands in bits [NW-1:0].
- R3: Full rises when there is no room for one more write word, counted in narrow units against a capacity of DEPTH*RATIO. A write attempted while full is dropped: no stored data changes and full stays high.
- R4: A read attempted while empty is dropped. The read position does not move, so the next word written is the next word read.
- R5: Each Gray-coded position that crosses a domain changes in at most one bit per clock of its source domain.
- R6: Almost-full equals (narrow words written minus narrow words known read) >= the almost-full level.
- R7: Almost-empty equals (narrow words known written minus narrow words read) <= the almost-empty level.
- R8: With THRESH_FROM_PORT=0 the levels come from AF_LEVEL and AE_LEVEL and the level inputs are ignored. With THRESH_FROM_PORT=1 the inputs af_level and ae_level set the levels and take effect at once.
- R9: With a narrow write side, a partially filled wide word cannot be read: empty stays high until RATIO narrow writes have been made and have crossed over.
- R10: Data leaves in the order it was written, with nothing lost or repeated, while both clocks run at unrelated rates.
- R11: With a narrow read side, each written wide word produces RATIO reads, bits [NW-1:0] first and then successively higher slices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | WR_W | Write word |
| wr_full | output | 1 | No room for one more write word |
| wr_almost_full | output | 1 | Write-side occupancy at or above the almost-full level |
| af_level | input | PW | Run-time almost-full level in narrow units |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain asynchronous reset, active low |
| rd_en | input | 1 | Read request, which advances past the presented word |
| rd_data | output | RD_W | Word at the head of the queue |
| rd_empty | output | 1 | No complete read word available |
| rd_almost_empty | output | 1 | Read-side occupancy at or below the almost-empty level |
| ae_level | input | PW | Run-time almost-empty level in narrow units |

## Verification
Some properties are checked on every clock edge:
- Neither side's view of the occupancy exceeds the capacity, which rules out overflow and underflow.
- Rejected writes and reads leave the positions untouched.
- Each crossing Gray value moves by at most one bit per clock.

The other behaviours can only be shown by the bench's scenarios:
- Slice ordering in both width directions, the end-to-end data order and the hiding of a half-packed word.
- The exact occupancy at which each flag switches.
- Which source feeds the flag levels.

The bench covers these with a queue-based scoreboard on two instances, one packing and one unpacking.

// File: rtl/xwidth_async_fifo.sv
`timescale 1ns/1ps
module xwidth_async_fifo #(
  parameter int WR_W = 8,
  parameter int RD_W = 32,
  parameter int DEPTH = 8,
  parameter bit THRESH_FROM_PORT = 1'b0,
  parameter int AF_LEVEL = 24,
  parameter int AE_LEVEL = 8,
  localparam int NW = (WR_W < RD_W) ? WR_W : RD_W,
  localparam int WW = (WR_W < RD_W) ? RD_W : WR_W,
  localparam int RATIO = WW / NW,
  localparam int LR = $clog2(RATIO),
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + LR + 1
) (
  input  logic            wr_clk,
  input  logic            wr_rst_n,
  input  logic            wr_en,
  input  logic [WR_W-1:0] wr_data,
  output logic            wr_full,
  output logic            wr_almost_full,
  input  logic [PW-1:0]   af_level,
  input  logic            rd_clk,
  input  logic            rd_rst_n,
  input  logic            rd_en,
  output logic [RD_W-1:0] rd_data,
  output logic            rd_empty,
  output logic            rd_almost_empty,
  input  logic [PW-1:0]   ae_level
);
  localparam bit WR_NARROW = WR_W < RD_W;
  localparam int WSH = WR_NARROW ? 0 : LR;
  localparam int RSH = WR_NARROW ? LR : 0;
  localparam int WXW = PW - WSH;
  localparam int RXW = PW - RSH;
  localparam int CAP = DEPTH * RATIO;
  localparam logic [PW-1:0] WSTEP = PW'(1 << WSH);
  localparam logic [PW-1:0] RSTEP = PW'(1 << RSH);
  localparam logic [PW-1:0] FULL_AT = PW'(CAP - (1 << WSH));

  logic [WW-1:0]  mem [DEPTH];
  logic [PW-1:0]  wptr, wptr_nx, r_seen, used_w, af_th;
  logic [PW-1:0]  rptr, rptr_nx, w_seen, avail_r, ae_th;
  logic [WXW-1:0] wgray, wg_s1, wg_s2, wx_bin;
  logic [RXW-1:0] rgray, rg_s1, rg_s2, rx_bin;
  logic [AW-1:0]  waddr, raddr;
  logic           push, pop;

  // write domain
  assign push    = wr_en & ~wr_full;
  assign wptr_nx = wptr + (push ? WSTEP : '0);
  assign waddr   = wptr[PW-2:LR];

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) begin
      wptr  <= '0;
      wgray <= '0;
      rg_s1 <= '0;
      rg_s2 <= '0;
    end else begin
      wptr  <= wptr_nx;
      wgray <= WXW'(wptr_nx >> WSH) ^ WXW'(wptr_nx >> (WSH + 1));
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
    end
  end

  always_comb
    for (int i = 0; i < RXW; i++) rx_bin[i] = ^(rg_s2 >> i);

  assign r_seen         = PW'(rx_bin) << RSH;
  assign used_w         = wptr - r_seen;
  assign af_th          = THRESH_FROM_PORT ? af_level : PW'(AF_LEVEL);
  assign wr_full        = used_w > FULL_AT;
  assign wr_almost_full = used_w >= af_th;

  // read domain
  assign pop     = rd_en & ~rd_empty;
  assign rptr_nx = rptr + (pop ? RSTEP : '0);
  assign raddr   = rptr[PW-2:LR];

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      rptr  <= '0;
      rgray <= '0;
      wg_s1 <= '0;
      wg_s2 <= '0;
    end else begin
      rptr  <= rptr_nx;
      rgray <= RXW'(rptr_nx >> RSH) ^ RXW'(rptr_nx >> (RSH + 1));
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
    end
  end

  always_comb
    for (int i = 0; i < WXW; i++) wx_bin[i] = ^(wg_s2 >> i);

  assign w_seen          = PW'(wx_bin) << WSH;
  assign avail_r         = w_seen - rptr;
  assign ae_th           = THRESH_FROM_PORT ? ae_level : PW'(AE_LEVEL);
  assign rd_empty        = avail_r < RSTEP;
  assign rd_almost_empty = avail_r <= ae_th;

  // storage: packing or unpacking variant
  generate
    if (WR_NARROW) begin : g_pack
      always_ff @(posedge wr_clk)
        if (push) mem[waddr][int'(wptr[LR-1:0]) * NW +: NW] <= wr_data;
      assign rd_data = mem[raddr];
    end else begin : g_unpack
      always_ff @(posedge wr_clk)
        if (push) mem[waddr] <= wr_data;
      assign rd_data = mem[raddr][int'(rptr[LR-1:0]) * NW +: NW];
    end
  endgenerate

  // assertions
  assert_no_overflow_R3: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    used_w <= PW'(CAP));
  assert_full_drop_R3: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_en && wr_full) |=> $stable(wptr));
  assert_no_underflow_R4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    avail_r <= PW'(CAP));
  assert_empty_drop_R4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_en && rd_empty) |=> $stable(rptr));
  assert_wgray_step_R5: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
  assert_rgray_step_R5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: tb/xwidth_async_fifo_bench.sv
`timescale 1ns/1ps
module xwidth_async_fifo_bench;
  logic wclk = 1'b0, rclk = 1'b0, wrst_n = 1'b0, rrst_n = 1'b0;
  always #2   wclk = ~wclk;
  always #3.5 rclk = ~rclk;

  int checks = 0, fails = 0;

  // instance A: 8 -> 32, parameter levels
  logic a_wen = 0, a_ren = 0, a_full, a_af, a_empty, a_ae;
  logic [7:0]  a_wdata = 0;
  logic [31:0] a_rdata;
  // instance B: 32 -> 8, port levels
  logic b_wen = 0, b_ren = 0, b_full, b_af, b_empty, b_ae;
  logic [31:0] b_wdata = 0;
  logic [7:0]  b_rdata;
  logic [5:0]  b_afl = 6'd8, b_ael = 6'd4;

  xwidth_async_fifo #(.WR_W(8), .RD_W(32), .DEPTH(8), .THRESH_FROM_PORT(1'b0),
    .AF_LEVEL(24), .AE_LEVEL(8)) u_xwidth_async_fifo (
    .wr_clk(wclk), .wr_rst_n(wrst_n), .wr_en(a_wen), .wr_data(a_wdata),
    .wr_full(a_full), .wr_almost_full(a_af), .af_level(6'd1),
    .rd_clk(rclk), .rd_rst_n(rrst_n), .rd_en(a_ren), .rd_data(a_rdata),
    .rd_empty(a_empty), .rd_almost_empty(a_ae), .ae_level(6'd30));

  xwidth_async_fifo #(.WR_W(32), .RD_W(8), .DEPTH(8), .THRESH_FROM_PORT(1'b1),
    .AF_LEVEL(24), .AE_LEVEL(8)) u_xwidth_async_fifo_dn (
    .wr_clk(wclk), .wr_rst_n(wrst_n), .wr_en(b_wen), .wr_data(b_wdata),
    .wr_full(b_full), .wr_almost_full(b_af), .af_level(b_afl),
    .rd_clk(rclk), .rd_rst_n(rrst_n), .rd_en(b_ren), .rd_data(b_rdata),
    .rd_empty(b_empty), .rd_almost_empty(b_ae), .ae_level(b_ael));

  logic [7:0] qa[$], qb[$];
  int a_budget = 0, b_budget = 0;
  bit a_force = 0;
  string a_tag = "R2", b_tag = "R11";

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // scoreboard monitors
  always @(negedge rclk) begin
    if (a_ren) a_ren = 1'b0;
    else if (a_force) a_ren = 1'b1;
    else if (a_budget > 0 && !a_empty) begin
      if (qa.size() < 4) chk(1'b0, a_tag, a_rdata, 32'hx);
      else begin
        chk(a_rdata == {qa[3], qa[2], qa[1], qa[0]}, a_tag, a_rdata, {qa[3], qa[2], qa[1], qa[0]});
        repeat (4) void'(qa.pop_front());
      end
      a_ren = 1'b1;
      a_budget--;
    end
  end

  always @(negedge rclk) begin
    if (b_ren) b_ren = 1'b0;
    else if (b_budget > 0 && !b_empty) begin
      if (qb.size() == 0) chk(1'b0, b_tag, b_rdata, 32'hx);
      else begin
        chk(b_rdata == qb[0], b_tag, b_rdata, qb[0]);
        void'(qb.pop_front());
      end
      b_ren = 1'b1;
      b_budget--;
    end
  end

  task automatic push_a(input logic [7:0] d, input bit track);
    @(negedge wclk);
    if (track) while (a_full) @(negedge wclk);
    a_wen = 1'b1; a_wdata = d;
    if (track) qa.push_back(d);
    @(negedge wclk);
    a_wen = 1'b0;
  endtask

  task automatic push_b(input logic [31:0] d);
    @(negedge wclk);
    while (b_full) @(negedge wclk);
    b_wen = 1'b1; b_wdata = d;
    for (int k = 0; k < 4; k++) qb.push_back(d[k*8 +: 8]);
    @(negedge wclk);
    b_wen = 1'b0;
  endtask

  task automatic read_a(input int n);
    @(posedge rclk) a_budget = n;
    while (a_budget != 0) @(posedge rclk);
    repeat (3) @(posedge rclk);
  endtask

  task automatic read_b(input int n);
    @(posedge rclk) b_budget = n;
    while (b_budget != 0) @(posedge rclk);
    repeat (3) @(posedge rclk);
  endtask

  task automatic settle;
    repeat (10) @(posedge rclk);
    repeat (4) @(negedge wclk);
    @(negedge rclk);
  endtask

  initial begin
    #800000;
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    #30 wrst_n = 1'b1; rrst_n = 1'b1;
    @(negedge rclk);
    // R1 reset state
    chk(a_empty == 1 && a_ae == 1, "R1 a read flags", {a_empty, a_ae}, 2'b11);
    chk(a_full == 0 && a_af == 0, "R1 a write flags", {a_full, a_af}, 2'b00);
    chk(b_empty == 1 && b_full == 0 && b_af == 0 && b_ae == 1, "R1 b flags",
        {b_empty, b_full, b_af, b_ae}, 4'b1001);

    // R9 partial word is hidden
    push_a(8'h11, 1); push_a(8'h22, 1); push_a(8'h33, 1);
    settle;
    chk(a_empty == 1, "R9 three of four slices", a_empty, 1);
    push_a(8'h44, 1);
    chk(a_af == 0, "R8 parameter level used, port ignored", a_af, 0);
    settle;
    chk(a_empty == 0, "R9 complete word visible", a_empty, 0);
    // R2 packing: 0x44332211 expected
    a_tag = "R2";
    read_a(1);
    chk(a_empty == 1, "R2 drained", a_empty, 1);
    settle;

    // R6 almost-full threshold at 24 narrow words
    for (int i = 0; i < 23; i++) push_a(8'(i + 8'h50), 1);
    chk(a_af == 0, "R6 at 23", a_af, 0);
    push_a(8'h67, 1);
    chk(a_af == 1, "R6 at 24", a_af, 1);
    for (int i = 0; i < 7; i++) push_a(8'(i + 8'h70), 1);
    chk(a_full == 0, "R3 at 31", a_full, 0);
    push_a(8'h77, 1);
    chk(a_full == 1, "R3 at 32", a_full, 1);
    push_a(8'hEE, 0);
    chk(a_full == 1, "R3 full after dropped write", a_full, 1);

    // R7 almost-empty at 8 narrow words (port value 30 ignored)
    settle;
    chk(a_ae == 0, "R7 32 readable", a_ae, 0);
    a_tag = "R3 data intact";
    read_a(5);
    @(negedge rclk);
    chk(a_ae == 0, "R7 12 readable", a_ae, 0);
    read_a(1);
    @(negedge rclk);
    chk(a_ae == 1, "R7 8 readable", a_ae, 1);
    read_a(2);
    @(negedge rclk);
    chk(a_empty == 1 && qa.size() == 0, "R3 dropped byte absent", qa.size(), 0);

    // R4 read while empty is dropped
    @(posedge rclk) a_force = 1'b1;
    @(posedge rclk) a_force = 1'b0;
    repeat (2) @(posedge rclk);
    @(negedge rclk);
    chk(a_empty == 1, "R4 still empty", a_empty, 1);
    push_a(8'hA1, 1); push_a(8'hA2, 1); push_a(8'hA3, 1); push_a(8'hA4, 1);
    settle;
    a_tag = "R4 next word after dropped read";
    read_a(1);

    // R10 / R5 streaming across unrelated clocks
    a_tag = "R10 R5 stream";
    @(posedge rclk) a_budget = 1000;
    for (int i = 0; i < 160; i++) push_a(8'((i * 37 + 5) & 8'hFF), 1);
    for (int t = 0; t < 3000 && qa.size() != 0; t++) @(posedge rclk);
    @(posedge rclk) a_budget = 0;
    chk(qa.size() == 0, "R10 all words delivered", qa.size(), 0);

    // instance B: R8 port levels, R11 unpacking
    push_b(32'hA3B2C1D0);
    chk(b_af == 0, "R8 port level 8, used 4", b_af, 0);
    push_b(32'h17263548);
    chk(b_af == 1, "R8 port level 8, used 8", b_af, 1);
    @(negedge wclk) b_afl = 6'd12;
    @(negedge wclk);
    chk(b_af == 0, "R8 port level raised to 12", b_af, 0);
    settle;
    chk(b_ae == 0, "R7 b 8 readable vs 4", b_ae, 0);
    b_tag = "R11 slice order";
    read_b(4);
    @(negedge rclk);
    chk(b_ae == 1, "R7 b 4 readable", b_ae, 1);
    read_b(4);
    @(negedge rclk);
    chk(b_empty == 1, "R11 b drained", b_empty, 1);
    settle;
    for (int i = 0; i < 8; i++) push_b(32'h01020304 * (i + 1));
    chk(b_full == 1, "R3 b full at 32", b_full, 1);
    b_tag = "R10 b stream";
    read_b(32);
    chk(qb.size() == 0 && b_empty == 1, "R10 b all delivered", qb.size(), 0);

    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule